// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a host a two-address window into a sparse configuration space. The host writes a register number to the even address of the window. It then reads or writes the chosen register through the odd address. Eleven configuration bytes have storage, and each one comes up with a fixed value after reset. Their contents go out on one flat bus to the address-decode and interrupt-routing logic next to the block.

Each data write that really alters a stored byte raises a one-cycle notice that carries the register number. Downstream logic uses it to re-evaluate only the function that depends on that register. Register numbers below a fixed floor read back as all ones. Numbers at or above the floor that have no storage read back as zero, and writes to them are dropped.

Top module: `cfg_index_port`

## Requirements
- R1: A write to the window base address (0x00F2, address bit 0 low) loads the index latch. A read of that address returns the latch value on `rdata` in the same cycle.
- R2: A read of the data address (0x00F3) while the index is below 0xBC returns 0xFF.
- R3: Storage exists at indices 0xBE, 0xBF, 0xDA, 0xDB, 0xDC, 0xDD, 0xDE, 0xDF, 0xFA, 0xFB and 0xFE. A data write to one of them is read back unchanged from the following cycle on.
- R4: A data write whose index has no storage changes no stored byte and raises no change notice. A data read of such an index at or above 0xBC returns 0x00.
- R5: The reset values are 0xBE=0xC0, 0xBF=0x9E, 0xDA=0xDE, 0xDB=0xC0, 0xDC=0xFE, 0xDD=0xBE, 0xDE=0xE2, 0xDF=0x18, 0xFA=0x00, 0xFB=0x00 and 0xFE=0xC0. The index latch resets to 0x00.
- R6: In the cycle after a data write that alters a stored byte, `chg_valid` is high for one cycle and `chg_index` holds the index. A data write of the value already stored raises no notice.
- R7: `cfg_q` carries the eleven stored bytes, one byte per slot. Slot 0 (bits 7:0) holds 0xBE, and the slots follow the ascending index order of R3, so slot 10 (bits 87:80) holds 0xFE.
- R8: An access whose address lies outside the two-byte window changes no state, and a read of such an address returns 0x00.
- R9: While `rd_en` is low, `rdata` is 0x00.
- R10: A synchronous active-high `rst` restores every stored byte and the index latch to the values of R5, whatever was written before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Host I/O address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational |
| cfg_q | output | 88 | Stored configuration bytes, one per slot |
| chg_valid | output | 1 | One-cycle notice that a stored byte changed |
| chg_index | output | 8 | Index of the byte that changed |

## Verification
A wrong index latch shows up in the very next data access. The read returns the wrong byte, 0xFF or 0x00 where a stored value was expected, and a write lands in the wrong slot of `cfg_q` one cycle later. A slot that fails to compare old and new values shows up in `chg_valid` in the cycle after the write: a notice either goes missing or appears for a rewrite of the same value. A wrong reset constant is visible on `cfg_q` in the first cycle after reset, before any bus traffic.

// File: rtl/cfg_index_port.sv
module cfg_index_port #(
  parameter int              AW    = 16,
  parameter logic [AW-1:0]   BASE  = 16'h00F2,
  parameter logic [7:0]      FLOOR = 8'hBC,
  parameter int              NREG  = 11,
  parameter logic [8*NREG-1:0] REG_IDX = {8'hFE, 8'hFB, 8'hFA, 8'hDF, 8'hDE, 8'hDD,
                                          8'hDC, 8'hDB, 8'hDA, 8'hBF, 8'hBE},
  parameter logic [8*NREG-1:0] REG_RST = {8'hC0, 8'h00, 8'h00, 8'h18, 8'hE2, 8'hBE,
                                          8'hFE, 8'hC0, 8'hDE, 8'h9E, 8'hC0}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [8*NREG-1:0] cfg_q,
  output logic              chg_valid,
  output logic [7:0]        chg_index
);

  logic            hit, sel_idx, sel_dat;
  logic [7:0]      idx_q;
  logic [NREG-1:0] match, differ;
  logic [7:0]      slot_rd;

  assign hit     = addr[AW-1:1] == BASE[AW-1:1];
  assign sel_idx = hit & ~addr[0];
  assign sel_dat = hit &  addr[0];

  always_ff @(posedge clk) begin
    if (rst)                  idx_q <= 8'h00;
    else if (wr_en & sel_idx) idx_q <= wdata;
  end

  for (genvar k = 0; k < NREG; k++) begin : g_slot
    assign match[k]  = idx_q == REG_IDX[8*k +: 8];
    assign differ[k] = cfg_q[8*k +: 8] != wdata;

    always_ff @(posedge clk) begin
      if (rst)                             cfg_q[8*k +: 8] <= REG_RST[8*k +: 8];
      else if (wr_en & sel_dat & match[k]) cfg_q[8*k +: 8] <= wdata;
    end
  end

  always_comb begin
    slot_rd = 8'h00;
    for (int k = 0; k < NREG; k++)
      if (match[k]) slot_rd = slot_rd | cfg_q[8*k +: 8];
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en & sel_idx)      rdata = idx_q;
    else if (rd_en & sel_dat) rdata = (idx_q < FLOOR) ? 8'hFF : slot_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_valid <= 1'b0;
      chg_index <= 8'h00;
    end else begin
      chg_valid <= wr_en & sel_dat & |(match & differ);
      if (wr_en & sel_dat) chg_index <= idx_q;
    end
  end

endmodule

module cfg_index_port_chk #(
  parameter int              AW    = 16,
  parameter logic [AW-1:0]   BASE  = 16'h00F2,
  parameter logic [7:0]      FLOOR = 8'hBC,
  parameter int              NREG  = 11,
  parameter logic [8*NREG-1:0] REG_RST = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [AW-1:0]     addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic [8*NREG-1:0] cfg_q,
  input logic              chg_valid,
  input logic [7:0]        chg_index,
  input logic [7:0]        idx_q
);
  logic wr_i, rd_i, wr_d, rd_d;
  assign wr_i = wr_en && addr == BASE;
  assign rd_i = rd_en && addr == BASE;
  assign wr_d = wr_en && addr == (BASE | 1);
  assign rd_d = rd_en && addr == (BASE | 1);

  p_idx_readback_r1: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (!rd_i || rdata == $past(wdata)));

  p_low_reads_ones_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_d && idx_q < FLOOR) |-> rdata == 8'hFF);

  p_low_write_inert_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_d && idx_q < FLOOR) |=> ($stable(cfg_q) && !chg_valid));

  p_chg_exact_r6: assert property (@(posedge clk) disable iff (rst)
    wr_d |=> (chg_valid == ($past(cfg_q) != cfg_q)));

  p_chg_needs_write_r6: assert property (@(posedge clk) disable iff (rst)
    chg_valid |-> $past(wr_d));

  p_outside_inert_r8: assert property (@(posedge clk) disable iff (rst)
    (addr[AW-1:1] != BASE[AW-1:1]) |=> ($stable(cfg_q) && $stable(idx_q)));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> rdata == 8'h00);

  p_reset_vals_r10: assert property (@(posedge clk)
    $past(rst) |-> (cfg_q == REG_RST && idx_q == 8'h00 && !chg_valid));
endmodule

bind cfg_index_port cfg_index_port_chk #(
  .AW(AW), .BASE(BASE), .FLOOR(FLOOR), .NREG(NREG), .REG_RST(REG_RST)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .cfg_q(cfg_q), .chg_valid(chg_valid),
  .chg_index(chg_index), .idx_q(idx_q)
);

// File: tb/cfg_index_port_bench.sv
module cfg_index_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [87:0] cfg_q;
  logic        chg_valid;
  logic [7:0]  chg_index;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cfg_index_port u_cfg_index_port (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cfg_q(cfg_q), .chg_valid(chg_valid),
    .chg_index(chg_index)
  );

  localparam int NV = 15;
  // {index, write value, expected read, expected change notice}
  localparam logic [24:0] VEC [NV] = '{
    {8'hBE, 8'h55, 8'h55, 1'b1}, {8'hBF, 8'h9E, 8'h9E, 1'b0},
    {8'hDA, 8'h12, 8'h12, 1'b1}, {8'hDB, 8'h3C, 8'h3C, 1'b1},
    {8'hDC, 8'h01, 8'h01, 1'b1}, {8'hDD, 8'hBE, 8'hBE, 1'b0},
    {8'hDE, 8'h1B, 8'h1B, 1'b1}, {8'hDF, 8'h77, 8'h77, 1'b1},
    {8'hFA, 8'hA5, 8'hA5, 1'b1}, {8'hFB, 8'h0F, 8'h0F, 1'b1},
    {8'hFE, 8'h00, 8'h00, 1'b1}, {8'hC0, 8'h33, 8'h00, 1'b0},
    {8'h10, 8'h44, 8'hFF, 1'b0}, {8'hBC, 8'h99, 8'h00, 1'b0},
    {8'hFF, 8'h12, 8'h00, 1'b0}
  };

  localparam logic [87:0] DEFS = {8'hC0, 8'h00, 8'h00, 8'h18, 8'hE2, 8'hBE,
                                  8'hFE, 8'hC0, 8'hDE, 8'h9E, 8'hC0};
  localparam logic [87:0] IDXS = {8'hFE, 8'hFB, 8'hFA, 8'hDF, 8'hDE, 8'hDD,
                                  8'hDC, 8'hDB, 8'hDA, 8'hBF, 8'hBE};

  task automatic check(string req, logic [87:0] act, logic [87:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = 16'h0000;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0; addr = 16'h0000;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R5 defaults", cfg_q, DEFS);
    check("R9 idle rdata", {80'h0, rdata}, 88'h0);
    rd(16'h00F2, v); check("R5 index reset", {80'h0, v}, 88'h0);

    for (int i = 0; i < NV; i++) begin
      wr(16'h00F2, VEC[i][24:17]);
      rd(16'h00F2, v); check("R1 index readback", {80'h0, v}, {80'h0, VEC[i][24:17]});
      @(negedge clk); addr = 16'h00F3; wdata = VEC[i][16:9]; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0; addr = 16'h0000;
      check("R6 notice", {87'h0, chg_valid}, {87'h0, VEC[i][0]});
      if (VEC[i][0]) check("R6 notice index", {80'h0, chg_index}, {80'h0, VEC[i][24:17]});
      @(negedge clk);
      check("R6 one cycle", {87'h0, chg_valid}, 88'h0);
      rd(16'h00F3, v);
      check("R3 R2 R4 data read", {80'h0, v}, {80'h0, VEC[i][8:1]});
    end

    check("R7 slot0", {80'h0, cfg_q[7:0]},   88'h55);
    check("R7 slot6", {80'h0, cfg_q[55:48]}, 88'h1B);
    check("R7 slot10", {80'h0, cfg_q[87:80]}, 88'h00);
    check("R4 no slot touched", {80'h0, cfg_q[15:8]}, 88'h9E);

    wr(16'h00F2, 8'hDA);
    wr(16'h00F4, 8'hBE);
    wr(16'h01F3, 8'h66);
    rd(16'h00F2, v); check("R8 index kept", {80'h0, v}, 88'hDA);
    rd(16'h00F3, v); check("R8 data kept", {80'h0, v}, 88'h12);
    rd(16'h00F5, v); check("R8 outside read", {80'h0, v}, 88'h0);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 reset restores", cfg_q, DEFS);
    rd(16'h00F2, v); check("R10 index cleared", {80'h0, v}, 88'h0);
    for (int k = 0; k < 11; k++) begin
      wr(16'h00F2, IDXS[8*k +: 8]);
      rd(16'h00F3, v); check("R5 default read", {80'h0, v}, {80'h0, DEFS[8*k +: 8]});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule